// File: doc/BRIEF.md
# Software-Managed Set-Associative Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit processor that uses 4 KB pages. It holds 16 lines of 4 ways. Each entry carries a 20-bit virtual page tag, an 8-bit process identifier, a 20-bit physical frame number and five permission flags: read, write, execute, global and cacheable. The lower bits of the virtual page number pick the line. A lookup port takes a virtual address and the current process identifier. One clock later it returns a hit flag, the frame and the flags.

Software fills and inspects the buffer only through three control registers: a page address register, a control register and an entry data register. A read command copies one way of the selected line into the three registers. With write mode armed, each write of the entry data register stores an entry and moves the way pointer on by one, so four writes in a row fill a whole line. A tag whose top two address bits are both set never matches. Software invalidates an entry by storing such a tag with an all-zero data word. Miss handling and page-table walks are left to the surrounding logic.

Top module: `stlb_top`

## Requirements
- R1: After reset all three registers read zero, the way pointer is 0, and every entry holds a never-matching tag (top two bits set, line number in the low bits), so no lookup hits.
- R2: The page address register (select 0) holds the virtual page number in bits [21:2]; all other bits read as zero.
- R3: The control register (select 1) has read command at bit 0, write mode at bit 1, way pointer at [5:4] and process ID at [23:16]; the read command bit always reads back as zero.
- R4: The entry data register (select 2) holds the frame number in [19:0] and the flags at bit 20 read, 21 write, 22 execute, 23 global and 24 cacheable; other bits read zero.
- R5: A write to the entry data register with write mode set stores into way (way pointer) of line (page number bits [3:0]) the tag from the page address register, the process ID from the control register, and the frame and flags from the written word.
- R6: Each such store increments the way pointer, wrapping from 3 to 0; an entry data write with write mode clear stores nothing and leaves the way pointer unchanged.
- R7: Writing the control register with the read command set, for the way given in that write, loads the entry's tag into the page address register, its process ID into the control register and its frame and flags into the entry data register.
- R8: A lookup hits when an entry of line vaddr[15:12] has tag equal to vaddr[31:12] and either the process ID matches or the global flag is set; hit, frame and flags appear on the outputs one clock after the lookup is presented.
- R9: A matching tag with a different process ID and the global flag clear gives a miss.
- R10: An entry whose tag has its top two bits set never hits, even for a lookup of that exact page; storing such a tag with an all-zero data word invalidates the entry.
- R11: In the cycle after an idle cycle or a miss, hit is low and frame and flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 page address, 1 control, 2 entry data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_pid | input | 8 | Current process ID |
| hit_o | output | 1 | Registered hit flag |
| pfn_o | output | 20 | Registered physical frame number |
| flags_o | output | 5 | Registered flags {cacheable, global, execute, write, read} |

## Verification
The checker watches on every cycle that the way pointer steps and wraps after each armed data write and stays put after an unarmed one. It also checks that idle cycles and misses leave the outputs quiet, that lookups in the top address region never hit, and that no more than one way of a line matches. Which entry lands in which way, what a read command copies back into the registers, whether a process ID match or the global flag wins, and whether an invalidation removes the old mapping can only be shown by the bench's scenarios, which fill a line, read entries back and look them up.

// File: rtl/stlb_pkg.sv
package stlb_pkg;
   localparam int VPN_W  = 20;
   localparam int PFN_W  = 20;
   localparam int FLAG_W = 5;
   localparam int DATA_W = 32;

   // flag bit order inside the flags vector
   localparam int FL_RD = 0;
   localparam int FL_WR = 1;
   localparam int FL_EX = 2;
   localparam int FL_GL = 3;
   localparam int FL_CA = 4;

   // register field positions
   localparam int PTE_LSB   = 2;
   localparam int CTL_RDCMD = 0;
   localparam int CTL_WMODE = 1;
   localparam int CTL_WAY_L = 4;
   localparam int CTL_PID_L = 16;
   localparam int ACC_FL_L  = 20;

   typedef enum logic [1:0] {
      SEL_PTE  = 2'd0,
      SEL_CTL  = 2'd1,
      SEL_ACC  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [FLAG_W-1:0] flags;
      logic [PFN_W-1:0]  pfn;
   } acc_t;

   function automatic logic [VPN_W-1:0] dead_tag(input int unsigned line);
      logic [VPN_W-1:0] t;
      t = VPN_W'(line);
      t[VPN_W-1 -: 2] = 2'b11;
      return t;
   endfunction

   function automatic logic tag_dead(input logic [VPN_W-1:0] t);
      return &t[VPN_W-1 -: 2];
   endfunction
endpackage

// File: rtl/stlb_store.sv
module stlb_store
   import stlb_pkg::*;
#(
   parameter int LINES = 16,
   parameter int WAYS  = 4,
   parameter int PID_W = 8,
   localparam int LINE_W = $clog2(LINES),
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [LINE_W-1:0]             wr_line,
   input  logic [WAY_W-1:0]              wr_way,
   input  logic [VPN_W-1:0]              wr_tag,
   input  logic [PID_W-1:0]              wr_pid,
   input  acc_t                          wr_acc,
   input  logic [LINE_W-1:0]             rd_line,
   input  logic [WAY_W-1:0]              rd_way,
   output logic [VPN_W-1:0]              rd_tag,
   output logic [PID_W-1:0]              rd_pid,
   output acc_t                          rd_acc,
   input  logic [LINE_W-1:0]             lk_line,
   output logic [WAYS-1:0][VPN_W-1:0]    lk_tag,
   output logic [WAYS-1:0][PID_W-1:0]    lk_pidv,
   output acc_t [WAYS-1:0]               lk_acc
);
   logic [LINES-1:0][WAYS-1:0][VPN_W-1:0] tag_q;
   logic [LINES-1:0][WAYS-1:0][PID_W-1:0] pid_q;
   acc_t [LINES-1:0][WAYS-1:0]            acc_q;

   for (genvar l = 0; l < LINES; l++) begin : g_line
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic sel_here;
         assign sel_here = wr_en && (wr_line == LINE_W'(l)) && (wr_way == WAY_W'(w));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tag_q[l][w] <= dead_tag(l);
               pid_q[l][w] <= '0;
               acc_q[l][w] <= '0;
            end else if (sel_here) begin
               tag_q[l][w] <= wr_tag;
               pid_q[l][w] <= wr_pid;
               acc_q[l][w] <= wr_acc;
            end
         end
      end
   end

   assign rd_tag  = tag_q[rd_line][rd_way];
   assign rd_pid  = pid_q[rd_line][rd_way];
   assign rd_acc  = acc_q[rd_line][rd_way];
   assign lk_tag  = tag_q[lk_line];
   assign lk_pidv = pid_q[lk_line];
   assign lk_acc  = acc_q[lk_line];
endmodule

// File: rtl/stlb_lookup.sv
module stlb_lookup
   import stlb_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int PID_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lk_valid,
   input  logic [VPN_W-1:0]           lk_vpn,
   input  logic [PID_W-1:0]           lk_pid,
   input  logic [WAYS-1:0][VPN_W-1:0] way_tag,
   input  logic [WAYS-1:0][PID_W-1:0] way_pid,
   input  acc_t [WAYS-1:0]            way_acc,
   output logic [WAYS-1:0]            match_vec,
   output logic                       hit_o,
   output logic [PFN_W-1:0]           pfn_o,
   output logic [FLAG_W-1:0]          flags_o
);
   acc_t [WAYS:0] sel_chain;

   assign sel_chain[0] = '0;
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      logic tag_eq, owner_ok;
      assign tag_eq    = (way_tag[w] == lk_vpn) && !tag_dead(way_tag[w]);
      assign owner_ok  = (way_pid[w] == lk_pid) || way_acc[w].flags[FL_GL];
      assign match_vec[w] = tag_eq && owner_ok;
      // AND-OR selection: relies on at most one way matching
      assign sel_chain[w+1] = sel_chain[w] | (way_acc[w] & {$bits(acc_t){match_vec[w]}});
   end

   logic any_hit;
   assign any_hit = lk_valid && (|match_vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_o   <= 1'b0;
         pfn_o   <= '0;
         flags_o <= '0;
      end else begin
         hit_o   <= any_hit;
         pfn_o   <= any_hit ? sel_chain[WAYS].pfn   : '0;
         flags_o <= any_hit ? sel_chain[WAYS].flags : '0;
      end
   end
endmodule

// File: rtl/stlb_ctrl.sv
module stlb_ctrl
   import stlb_pkg::*;
#(
   parameter int LINES = 16,
   parameter int WAYS  = 4,
   parameter int PID_W = 8,
   localparam int LINE_W = $clog2(LINES),
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [1:0]         reg_sel,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               st_wr_en,
   output logic [LINE_W-1:0]  st_line,
   output logic [WAY_W-1:0]   st_wr_way,
   output logic [VPN_W-1:0]   st_wr_tag,
   output logic [PID_W-1:0]   st_wr_pid,
   output acc_t               st_wr_acc,
   output logic [WAY_W-1:0]   st_rd_way,
   input  logic [VPN_W-1:0]   st_rd_tag,
   input  logic [PID_W-1:0]   st_rd_pid,
   input  acc_t               st_rd_acc,
   output logic [WAY_W-1:0]   cur_way,
   output logic               cur_we
);
   logic [VPN_W-1:0] vpn_q;
   logic [PID_W-1:0] pid_q;
   logic [WAY_W-1:0] way_q;
   logic             we_q;
   acc_t             acc_q;

   logic  pte_wr, ctl_wr, acc_wr, rd_cmd;
   acc_t  wacc;

   assign pte_wr = reg_wr && (reg_sel == SEL_PTE);
   assign ctl_wr = reg_wr && (reg_sel == SEL_CTL);
   assign acc_wr = reg_wr && (reg_sel == SEL_ACC);
   assign rd_cmd = ctl_wr && reg_wdata[CTL_RDCMD];
   assign wacc.pfn   = reg_wdata[PFN_W-1:0];
   assign wacc.flags = reg_wdata[ACC_FL_L +: FLAG_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpn_q <= '0;
         pid_q <= '0;
         way_q <= '0;
         we_q  <= 1'b0;
         acc_q <= '0;
      end else begin
         if (pte_wr) vpn_q <= reg_wdata[PTE_LSB +: VPN_W];
         if (ctl_wr) begin
            we_q  <= reg_wdata[CTL_WMODE];
            way_q <= reg_wdata[CTL_WAY_L +: WAY_W];
            if (rd_cmd) begin
               vpn_q <= st_rd_tag;
               pid_q <= st_rd_pid;
               acc_q <= st_rd_acc;
            end else begin
               pid_q <= reg_wdata[CTL_PID_L +: PID_W];
            end
         end
         if (acc_wr) begin
            acc_q <= wacc;
            if (we_q) way_q <= way_q + 1'b1;
         end
      end
   end

   assign st_wr_en  = acc_wr && we_q;
   assign st_line   = vpn_q[LINE_W-1:0];
   assign st_wr_way = way_q;
   assign st_wr_tag = vpn_q;
   assign st_wr_pid = pid_q;
   assign st_wr_acc = wacc;
   assign st_rd_way = reg_wdata[CTL_WAY_L +: WAY_W];
   assign cur_way   = way_q;
   assign cur_we    = we_q;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel)
         SEL_PTE: reg_rdata[PTE_LSB +: VPN_W] = vpn_q;
         SEL_CTL: begin
            reg_rdata[CTL_WMODE]            = we_q;
            reg_rdata[CTL_WAY_L +: WAY_W]   = way_q;
            reg_rdata[CTL_PID_L +: PID_W]   = pid_q;
         end
         SEL_ACC: begin
            reg_rdata[PFN_W-1:0]            = acc_q.pfn;
            reg_rdata[ACC_FL_L +: FLAG_W]   = acc_q.flags;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/stlb_top.sv
module stlb_top
   import stlb_pkg::*;
#(
   parameter int LINES = 16,
   parameter int WAYS  = 4,
   parameter int PID_W = 8,
   localparam int LINE_W = $clog2(LINES),
   localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              lk_valid,
   input  logic [31:0]       lk_vaddr,
   input  logic [PID_W-1:0]  lk_pid,
   output logic              hit_o,
   output logic [19:0]       pfn_o,
   output logic [4:0]        flags_o
);
   if ((1 << LINE_W) != LINES) begin : g_chk_lines
      $error("LINES must be a power of two");
   end
   if ((1 << WAY_W) != WAYS || WAYS < 2) begin : g_chk_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (PID_W > 8 || WAY_W > 2) begin : g_chk_fields
      $error("process ID or way field exceeds its register slot");
   end
   if (LINE_W > VPN_W - 2) begin : g_chk_index
      $error("line index overlaps the dead-region bits");
   end

   logic [VPN_W-1:0] lk_vpn;
   assign lk_vpn = lk_vaddr[31 -: VPN_W];

   logic                     st_wr_en;
   logic [LINE_W-1:0]        st_line;
   logic [WAY_W-1:0]         st_wr_way, st_rd_way;
   logic [VPN_W-1:0]         st_wr_tag, st_rd_tag;
   logic [PID_W-1:0]         st_wr_pid, st_rd_pid;
   acc_t                     st_wr_acc, st_rd_acc;
   logic [WAYS-1:0][VPN_W-1:0] lk_tag;
   logic [WAYS-1:0][PID_W-1:0] lk_pidv;
   acc_t [WAYS-1:0]          lk_acc;
   logic [WAYS-1:0]          match_vec;
   logic [WAY_W-1:0]         cur_way;
   logic                     cur_we;

   stlb_ctrl #(.LINES(LINES), .WAYS(WAYS), .PID_W(PID_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .st_wr_en(st_wr_en), .st_line(st_line), .st_wr_way(st_wr_way),
      .st_wr_tag(st_wr_tag), .st_wr_pid(st_wr_pid), .st_wr_acc(st_wr_acc),
      .st_rd_way(st_rd_way), .st_rd_tag(st_rd_tag), .st_rd_pid(st_rd_pid),
      .st_rd_acc(st_rd_acc), .cur_way(cur_way), .cur_we(cur_we)
   );

   stlb_store #(.LINES(LINES), .WAYS(WAYS), .PID_W(PID_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(st_wr_en), .wr_line(st_line), .wr_way(st_wr_way),
      .wr_tag(st_wr_tag), .wr_pid(st_wr_pid), .wr_acc(st_wr_acc),
      .rd_line(st_line), .rd_way(st_rd_way),
      .rd_tag(st_rd_tag), .rd_pid(st_rd_pid), .rd_acc(st_rd_acc),
      .lk_line(lk_vpn[LINE_W-1:0]), .lk_tag(lk_tag), .lk_pidv(lk_pidv), .lk_acc(lk_acc)
   );

   stlb_lookup #(.WAYS(WAYS), .PID_W(PID_W)) u_lookup (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
      .way_tag(lk_tag), .way_pid(lk_pidv), .way_acc(lk_acc),
      .match_vec(match_vec), .hit_o(hit_o), .pfn_o(pfn_o), .flags_o(flags_o)
   );
endmodule

// File: rtl/stlb_chk.sv
module stlb_chk #(
   parameter int WAYS  = 4,
   parameter int WAY_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [1:0]       reg_sel,
   input logic             lk_valid,
   input logic [31:0]      lk_vaddr,
   input logic             hit_o,
   input logic [19:0]      pfn_o,
   input logic [4:0]       flags_o,
   input logic [WAYS-1:0]  match_vec,
   input logic [WAY_W-1:0] cur_way,
   input logic             cur_we
);
   logic [WAY_W-1:0] way_next;
   assign way_next = cur_way + 1'b1;

   a_r6_way_step: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd2 && cur_we) |=> (cur_way == $past(way_next)));

   a_r6_way_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd2 && !cur_we) |=> $stable(cur_way));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !hit_o);

   a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (pfn_o == '0 && flags_o == '0));

   a_r10_region_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_vaddr[31:30] == 2'b11) |=> !hit_o);

   a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));
endmodule

bind stlb_top stlb_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
   .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .hit_o(hit_o), .pfn_o(pfn_o),
   .flags_o(flags_o), .match_vec(match_vec), .cur_way(cur_way), .cur_we(cur_we)
);

// File: tb/stlb_top_tb.sv
module stlb_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd3;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic [7:0]  lk_pid = '0;
   logic        hit_o;
   logic [19:0] pfn_o;
   logic [4:0]  flags_o;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   stlb_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
      .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .hit_o(hit_o), .pfn_o(pfn_o),
      .flags_o(flags_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = 2'd3;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b0; reg_sel = sel;
      #1 d = reg_rdata;
   endtask

   // returns {hit, flags, pfn} one clock after presenting the lookup
   task automatic look(input logic [31:0] va, input logic [7:0] pid, output logic [31:0] r);
      @(negedge clk);
      lk_valid = 1'b1; lk_vaddr = va; lk_pid = pid;
      @(negedge clk);
      lk_valid = 1'b0;
      r = {6'd0, hit_o, flags_o, pfn_o};
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd0, v); check("R1 page reg after reset", v, 32'h0);
      rd(2'd1, v); check("R1 control reg after reset", v, 32'h0);
      rd(2'd2, v); check("R1 data reg after reset", v, 32'h0);
      look(32'h0000_0000, 8'd0, v); check("R1 lookup miss after reset", v, 32'h0);
      look(32'hC000_0000, 8'd0, v); check("R10 reset tag never hits", v, 32'h0);
   endtask

   task automatic t_layout();
      logic [31:0] v;
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R2 page reg field", v, 32'h003F_FFFC);
      wr(2'd1, 32'hFFFF_FFFE); rd(2'd1, v); check("R3 control reg fields", v, 32'h00FF_0032);
      wr(2'd1, 32'h0000_0000);
      wr(2'd2, 32'hFFFF_FFFF); rd(2'd2, v); check("R4 data reg fields", v, 32'h01FF_FFFF);
   endtask

   task automatic t_fill();
      logic [31:0] v;
      wr(2'd1, 32'h0007_0002);                        // write mode, way 0, pid 7
      for (int w = 0; w < 4; w++) begin
         wr(2'd0, (32'h12345 + 32'(w) * 32'h10) << 2); // same line 5
         wr(2'd2, 32'h0010_0100 + 32'(w));             // read flag, pfn 0x100+w
      end
      rd(2'd1, v); check("R6 way pointer wrapped to 0", v, 32'h0007_0002);
      for (int w = 0; w < 4; w++) begin
         look((32'h12345 + 32'(w) * 32'h10) << 12, 8'd7, v);
         check("R5 R8 filled entry hits", v, {6'd0, 1'b1, 5'h01, 20'h00100 + 20'(w)});
      end
   endtask

   task automatic t_readback();
      logic [31:0] v;
      wr(2'd1, 32'h0055_0021);                        // read command, way 2, stray pid
      rd(2'd0, v); check("R7 tag loaded", v, 32'h0004_8D94);
      rd(2'd1, v); check("R7 pid and way loaded", v, 32'h0007_0020);
      rd(2'd2, v); check("R7 frame and flags loaded", v, 32'h0010_0102);
   endtask

   task automatic t_owner();
      logic [31:0] v;
      look(32'h1234_5000, 8'd8, v); check("R9 foreign pid misses", v, 32'h0);
      wr(2'd0, 32'h0000_0024);                        // page 9
      wr(2'd1, 32'h0003_0002);
      wr(2'd2, 32'h0090_0077);                        // global + read
      look(32'h0000_9ABC, 8'h99, v); check("R8 global entry hits any pid", v, {6'd0, 1'b1, 5'h09, 20'h00077});
   endtask

   task automatic t_no_store();
      logic [31:0] v;
      wr(2'd1, 32'h0007_0010);                        // way 1, write mode clear
      wr(2'd0, 32'h0004_8D54);                        // page 0x12355
      wr(2'd2, 32'h0000_0ABC);
      rd(2'd1, v); check("R6 way held without write mode", v, 32'h0007_0010);
      look(32'h1235_5000, 8'd7, v); check("R6 entry untouched", v, {6'd0, 1'b1, 5'h01, 20'h00101});
   endtask

   task automatic t_invalidate();
      logic [31:0] v;
      wr(2'd0, 32'h0030_0014);                        // dead tag for line 5
      wr(2'd1, 32'h0007_0002);                        // way 0
      wr(2'd2, 32'h0000_0000);
      look(32'h1234_5000, 8'd7, v); check("R10 invalidated entry misses", v, 32'h0);
      check("R11 miss outputs zero", {12'd0, flags_o, pfn_o}, 32'h0);
      wr(2'd0, 32'h0030_48D4);                        // page 0xC1235 into way 1
      wr(2'd2, 32'h0010_0055);
      look(32'hC123_5000, 8'd7, v); check("R10 top region tag never hits", v, 32'h0);
      look(32'h1236_5000, 8'd7, v); check("R5 neighbour way intact", v, {6'd0, 1'b1, 5'h01, 20'h00102});
      @(negedge clk);
      check("R11 idle cycle after hit is quiet", {11'd0, hit_o, flags_o, pfn_o}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_fill();
      t_readback();
      t_owner();
      t_no_store();
      t_invalidate();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule